// File: doc/BRIEF.md
# Packed Compare, Select and Average Unit

A 64-bit element-wise vector unit. It splits both operands into lanes of 8, 16 or 32 bits and applies one operation to every lane pair at once. The operations are equality and greater-than masks, signed and unsigned minimum and maximum, wrapping add and subtract, and a rounding or truncating average on byte and halfword lanes. No carry or borrow crosses from one lane into the next.

Along with the 64-bit result the unit produces a 32-bit status word. It holds a negative flag and a zero flag for each result lane, and the bit positions of these flags depend on the lane width. A caller presents the operands, lane size, operation and rounding control with a one-cycle start pulse. The result and the status word are captured together on that clock edge and stay unchanged until the next start.

Top module: `simd_cas_unit`

## Requirements
- R1: After reset, and before any start pulse, `result_o` and `status_o` are both zero.
- R2: Size codes are 00 = 8-bit lanes, 01 = 16-bit lanes and 10 = 32-bit lanes. Compare ops are 0 = equal, 1 = signed greater-than and 2 = unsigned greater-than, with a > b meaning lane of `a_i` greater than lane of `b_i`. Each result lane is all ones when the condition holds and all zeros when it does not.
- R3: Op 3 = signed minimum, 4 = unsigned minimum, 5 = signed maximum and 6 = unsigned maximum. Each result lane is an unchanged copy of the chosen operand's lane.
- R4: Op 7 = add and op 8 = subtract (a − b). Each lane wraps modulo 2^lane-width, and no carry or borrow reaches a neighbouring lane.
- R5: Op 9 = average. Each lane is (a + b + `round_i`) >> 1, computed one bit wider than the lane so the carry is kept. It is valid for 8-bit and 16-bit lanes only.
- R6: For ops 0 to 8, take lane i of width W and n = 64/W lanes. Status bit (32/n)(i+1)−1 is the MSB of result lane i, and bit (32/n)(i+1)−2 is set when result lane i is all zeros. Every other status bit is zero.
- R7: For op 9, only the per-lane zero flags (the positions given in R6) can be set. The negative flag positions and all other status bits are zero.
- R8: Size code 11, op codes 10 to 15, and op 9 with 32-bit lanes all produce a zero result and a zero status word.
- R9: Result and status are captured together on the rising clock edge at which `start_i` is high. While `start_i` is low they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture the operation result on this edge |
| size_i | input | 2 | Lane size code |
| op_i | input | 4 | Operation code |
| round_i | input | 1 | Average rounding control (1 = round up) |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| result_o | output | 64 | Registered lane-wise result |
| status_o | output | 32 | Registered per-lane negative and zero flags |

## Verification
The only state in the unit is the output register pair, so any internal fault shows at the ports on the first clock after the offending start pulse. A lane that leaks a carry or mis-selects its signedness corrupts `result_o` in that same cycle. A flag placed for the wrong lane width shows as a mismatch in `status_o`. A missed hold or capture appears as a stale or changed output in the cycle that follows. Because the reference model is compared on every clock, such errors are reported within one cycle of the operation that exposes them.

// File: rtl/simd_cas_pkg.sv
package simd_cas_pkg;
  localparam int unsigned STATUS_W = 32;

  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_GTS  = 4'd1,
    OP_GTU  = 4'd2,
    OP_MINS = 4'd3,
    OP_MINU = 4'd4,
    OP_MAXS = 4'd5,
    OP_MAXU = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_AVG  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } size_e;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_cas_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  op_e               op_i,
  input  logic              round_i,
  output logic [LANE_W-1:0] res_o
);
  logic          eq, s_gt, s_lt, u_gt, u_lt;
  logic [LANE_W:0] avg_sum;

  always_comb begin
    eq      = (a_i == b_i);
    s_gt    = $signed(a_i) > $signed(b_i);
    s_lt    = $signed(a_i) < $signed(b_i);
    u_gt    = a_i > b_i;
    u_lt    = a_i < b_i;
    // one extra bit keeps the carry of a + b + r
    avg_sum = {1'b0, a_i} + {1'b0, b_i} + {{LANE_W{1'b0}}, round_i};
    unique case (op_i)
      OP_EQ:   res_o = {LANE_W{eq}};
      OP_GTS:  res_o = {LANE_W{s_gt}};
      OP_GTU:  res_o = {LANE_W{u_gt}};
      OP_MINS: res_o = s_lt ? a_i : b_i;
      OP_MINU: res_o = u_lt ? a_i : b_i;
      OP_MAXS: res_o = s_gt ? a_i : b_i;
      OP_MAXU: res_o = u_gt ? a_i : b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AVG:  res_o = avg_sum[LANE_W:1];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice
  import simd_cas_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  op_e                 op_i,
  input  logic                round_i,
  output logic [DATA_W-1:0]   res_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned STRIDE = STATUS_W / LANES;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_lane_op #(.LANE_W(LANE_W)) u_lane (
      .a_i     (a_i[i*LANE_W +: LANE_W]),
      .b_i     (b_i[i*LANE_W +: LANE_W]),
      .op_i    (op_i),
      .round_i (round_i),
      .res_o   (res_o[i*LANE_W +: LANE_W])
    );
  end

  // flag slot per lane: top bit N, next bit Z, remainder zero
  always_comb begin
    status_o = '0;
    for (int i = 0; i < LANES; i++) begin
      status_o[STRIDE*(i+1)-1] = (op_i != OP_AVG) && res_o[i*LANE_W + LANE_W - 1];
      status_o[STRIDE*(i+1)-2] = (res_o[i*LANE_W +: LANE_W] == '0);
    end
  end
endmodule

// File: rtl/simd_cas_unit.sv
module simd_cas_unit
  import simd_cas_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          size_i,
  input  logic [3:0]          op_i,
  input  logic                round_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W-1:0]   result_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int unsigned NUM_W  = 3;
  localparam int unsigned WORD_W = 32;

  op_e                 op;
  logic [DATA_W-1:0]   res_w [NUM_W];
  logic [STATUS_W-1:0] st_w  [NUM_W];
  logic                legal;
  logic [DATA_W-1:0]   res_d;
  logic [STATUS_W-1:0] st_d;

  assign op = op_e'(op_i);

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    simd_width_slice #(.DATA_W(DATA_W), .LANE_W(8 << g)) u_slice (
      .a_i      (a_i),
      .b_i      (b_i),
      .op_i     (op),
      .round_i  (round_i),
      .res_o    (res_w[g]),
      .status_o (st_w[g])
    );
  end

  always_comb begin
    legal = (op_i <= 4'(OP_AVG)) && (size_i != SZ_NONE) &&
            !((op_i == 4'(OP_AVG)) && (size_i == SZ_WORD));
    res_d = '0;
    st_d  = '0;
    if (legal) begin
      unique case (size_i)
        SZ_BYTE: begin res_d = res_w[0]; st_d = st_w[0]; end
        SZ_HALF: begin res_d = res_w[1]; st_d = st_w[1]; end
        SZ_WORD: begin res_d = res_w[2]; st_d = st_w[2]; end
        default: begin res_d = '0;       st_d = '0;       end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      status_o <= '0;
    end else if (start_i) begin
      result_o <= res_d;
      status_o <= st_d;
    end
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o) && $stable(status_o));

  // R8
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (size_i == SZ_NONE) |=> (result_o == '0) && (status_o == '0));

  // R7
  avg_no_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (op_i == 4'(OP_AVG)) && (size_i == SZ_BYTE)
    |=> (status_o & 32'h8888_8888) == '0);

  // R6
  byte_spare_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (size_i == SZ_BYTE) |=> (status_o & 32'h3333_3333) == '0);

  // R6
  word_zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (size_i == SZ_WORD) && (op_i < 4'(OP_AVG))
    |=> status_o[14] == (result_o[WORD_W-1:0] == '0));

  // R2
  word_eq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (size_i == SZ_WORD) && (op_i == 4'(OP_EQ))
    |=> (result_o[WORD_W-1:0] == '0) || (result_o[WORD_W-1:0] == '1));
endmodule

// File: tb/simd_cas_unit_bench.sv
`timescale 1ns/1ps
module simd_cas_unit_bench;
  localparam time T_CLK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [3:0]  op = 4'd0;
  logic        rnd = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] res;
  logic [31:0] st;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] exp_res = '0;
  logic [31:0] exp_st = '0;
  string       tag_res = "R1";
  string       tag_st  = "R1";

  always #(T_CLK/2) clk = ~clk;

  simd_cas_unit u_simd_cas_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .op_i(op),
    .round_i(rnd), .a_i(a), .b_i(b), .result_o(res), .status_o(st)
  );

  function automatic bit illegal(input int sz, input int o);
    return (sz == 3) || (o > 9) || (o == 9 && sz == 2);
  endfunction

  function automatic void ref_calc(input logic [63:0] x, input logic [63:0] y,
                                   input int sz, input int o, input bit r,
                                   output logic [63:0] rr, output logic [31:0] ss);
    int w, n, stride;
    longint m, ua, ub, sa, sb, v;
    rr = '0;
    ss = '0;
    if (illegal(sz, o)) return;
    w = 8 << sz;
    n = 64 / w;
    stride = 32 / n;
    m = (longint'(1) << w) - 1;
    for (int i = 0; i < n; i++) begin
      ua = longint'(x >> (i*w)) & m;
      ub = longint'(y >> (i*w)) & m;
      sa = (ua >= (longint'(1) << (w-1))) ? ua - (longint'(1) << w) : ua;
      sb = (ub >= (longint'(1) << (w-1))) ? ub - (longint'(1) << w) : ub;
      case (o)
        0: v = (ua == ub) ? m : 0;
        1: v = (sa > sb) ? m : 0;
        2: v = (ua > ub) ? m : 0;
        3: v = (sa < sb) ? ua : ub;
        4: v = (ua < ub) ? ua : ub;
        5: v = (sa > sb) ? ua : ub;
        6: v = (ua > ub) ? ua : ub;
        7: v = (ua + ub) & m;
        8: v = (ua - ub) & m;
        default: v = (ua + ub + longint'(r)) >> 1;
      endcase
      rr = rr | (64'(v) << (i*w));
      if (o != 9) ss[stride*(i+1)-1] = ((v >> (w-1)) & 1) != 0;
      ss[stride*(i+1)-2] = (v == 0);
    end
  endfunction

  // reference model updated on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_res = '0; exp_st = '0; tag_res = "R1"; tag_st = "R1";
    end else if (start) begin
      ref_calc(a, b, int'(size), int'(op), rnd, exp_res, exp_st);
      if (illegal(int'(size), int'(op))) begin tag_res = "R8"; tag_st = "R8"; end
      else if (op <= 2) begin tag_res = "R2"; tag_st = "R6"; end
      else if (op <= 6) begin tag_res = "R3"; tag_st = "R6"; end
      else if (op <= 8) begin tag_res = "R4"; tag_st = "R6"; end
      else begin tag_res = "R5"; tag_st = "R7"; end
    end else begin
      tag_res = "R9"; tag_st = "R9";
    end
  end

  task automatic compare();
    checks++;
    if (res !== exp_res) begin
      fails++;
      $display("FAIL %s result actual=%h expected=%h", tag_res, res, exp_res);
    end
    checks++;
    if (st !== exp_st) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h", tag_st, st, exp_st);
    end
  endtask

  task automatic step(input bit s, input logic [1:0] sz, input logic [3:0] o,
                      input bit r, input logic [63:0] x, input logic [63:0] y);
    start = s; size = sz; op = o; rnd = r; a = x; b = y;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();  // R1 reset state
    // R2 compares
    step(1, 2'd0, 4'd0, 0, 64'h0011_2233_4455_6677, 64'h0011_0033_0055_0077);
    step(1, 2'd0, 4'd1, 0, 64'h8080_7F7F_0102_FF00, 64'h7F7F_8080_0201_00FF);
    step(1, 2'd0, 4'd2, 0, 64'h8080_7F7F_0102_FF00, 64'h7F7F_8080_0201_00FF);
    step(1, 2'd2, 4'd0, 0, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0002);
    // R3 min/max
    step(1, 2'd1, 4'd3, 0, 64'h8000_0001_7FFF_FFFF, 64'h0001_8000_FFFF_7FFF);
    step(1, 2'd1, 4'd4, 0, 64'h8000_0001_7FFF_FFFF, 64'h0001_8000_FFFF_7FFF);
    step(1, 2'd2, 4'd5, 0, 64'h8000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF);
    step(1, 2'd2, 4'd6, 0, 64'h8000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF);
    // R4 wrap without lane carry
    step(1, 2'd0, 4'd7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    step(1, 2'd1, 4'd8, 0, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001);
    step(1, 2'd2, 4'd7, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    // R5 / R7 average carry and rounding
    step(1, 2'd0, 4'd9, 1, 64'hFFFF_0100_0001_0203, 64'hFFFF_0000_0100_0302);
    step(1, 2'd0, 4'd9, 0, 64'hFFFF_0100_0001_0203, 64'hFFFF_0000_0100_0302);
    step(1, 2'd1, 4'd9, 1, 64'hFFFF_0001_8000_0000, 64'hFFFF_0000_8000_0000);
    // R8 illegal forms
    step(1, 2'd2, 4'd9, 1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    step(1, 2'd3, 4'd7, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    step(1, 2'd0, 4'd12, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    // R9 hold while idle
    step(1, 2'd0, 4'd7, 0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010);
    step(0, 2'd1, 4'd8, 1, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1234_5678_9ABC_DEF0);
    step(0, 2'd3, 4'd0, 0, '0, '0);
    // mixed sweep
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = ($urandom_range(0, 3) == 0) ? x : {$urandom, $urandom};
      if ($urandom_range(0, 4) == 0) y[31:16] = x[31:16];
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
           4'($urandom_range(0, 11)), 1'($urandom_range(0, 1)), x, y);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(T_CLK * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule